// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block takes level-sensitive interrupt requests from a set of sources and drives one interrupt line to each processor. Each source has a programmable priority, vector, destination processor and mask. Source 0 is the request line of a cascaded legacy interrupt controller. The block handles it as one opaque source, with a vector and an in-service bit like any other source. The legacy controller's own vector fetch goes to that controller and never reaches this block's register space.

A processor services an interrupt by reading its acknowledge register. That read returns the vector of the winning request and marks the source in service in the same cycle. While a source is in service, only requests of strictly higher priority raise that processor's line again. An end-of-interrupt write to the processor's own register clears its highest-priority in-service mark, so nested service unwinds in priority order.

Top module: `prio_intc`

## Requirements
- R1: After reset every source is masked, with priority 0, vector 0 and destination 0. The spurious vector is 0xFF, every `int_out` bit is low and no source is in service.
- R2: The source configuration register of source s is at address 0x10000 + 16*s. Its fields are vector in bits [7:0], priority in bits [19:16], destination processor in bit 24 and mask in bit 31. A write sets all four fields and a read returns them with the other bits zero. The spurious-vector register is at 0x01000, in bits [7:0].
- R3: `int_out[c]` is high exactly when some unmasked, asserted source that is not in service has destination c and a priority above processor c's current level. A source of priority 0 never interrupts.
- R4: A read of processor c's acknowledge register returns the vector of the eligible source with the highest priority. Among sources of equal priority the lowest-numbered one wins.
- R5: The acknowledge read marks the winner in service at the same clock edge. The same source can then not be acknowledged again until its end-of-interrupt.
- R6: A processor's current level is the highest priority among its in-service sources, or 0 if there are none. Requests of equal or lower priority are held off, and strictly higher ones still assert `int_out[c]`.
- R7: An end-of-interrupt write to processor c clears only the in-service bit of c's highest-priority in-service source, with ties going to the lowest-numbered source. Any write data is accepted.
- R8: An acknowledge read with no eligible request returns the spurious vector and marks nothing in service.
- R9: A masked source takes no part in arbitration. It keeps its in-service bit, which still sets the level, and an end-of-interrupt still clears it.
- R10: `int_out` follows the request inputs with no register in between. It falls in the same cycle in which the winning request drops.
- R11: Source 0 is driven by `cascade_irq` and is arbitrated like any other source. A read of an address outside the decoded registers returns 0 and changes no state.
- R12: Processor c's acknowledge register is at 0x200A0 + (c << 12) and its end-of-interrupt register is at 0x200B0 + (c << 12). An access through one processor's registers leaves the other processor's in-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cascade_irq | input | 1 | Level request from the cascaded legacy controller (source 0) |
| dev_irq | input | NUM_SRC-1 | Level requests of sources 1 to NUM_SRC-1 |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| int_out | output | NUM_CPU | Interrupt line to each processor |

## Verification
A stale or missing in-service bit changes the processor's level. The effect shows at `int_out` in the same cycle as a line that stays low when it should be high, or high when it should be low. It also shows in the vector returned by the next acknowledge. A wrong stack pop shows up when a later request of middle priority is held off or let through against the model. A model of the queue of in-service sources is compared with `int_out` in every cycle and with every read, during directed nesting sequences and a random phase.

// File: rtl/prio_intc_pkg.sv
// Shared constants of the nested priority interrupt controller.
// Assumes 32-bit data and a 4 KB register page per address bits [ADDR_W-1:12].
package prio_intc_pkg;
    localparam int PAGE_SPUR = 'h01;
    localparam int PAGE_CFG  = 'h10;
    localparam int PAGE_CPU0 = 'h20;
    localparam int OFF_ACK   = 'h0A0;
    localparam int OFF_EOI   = 'h0B0;
    localparam int FLD_VEC   = 0;
    localparam int FLD_PRIO  = 16;
    localparam int FLD_DEST  = 24;
    localparam int FLD_MASK  = 31;

    // Width of an index over n items, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/prio_intc_src_cfg.sv
// Per-source configuration storage: vector, priority, destination, mask.
// Assumes the decode upstream asserts wr_en only for an in-range wr_idx.
module prio_intc_src_cfg #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 8,
    parameter int CPU_W   = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SRC_W-1:0]                wr_idx,
    input  logic [VEC_W-1:0]                wr_vec,
    input  logic [PRIO_W-1:0]               wr_prio,
    input  logic [CPU_W-1:0]                wr_dest,
    input  logic                            wr_mask,
    output logic [NUM_SRC-1:0][VEC_W-1:0]   vec_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [NUM_SRC-1:0][CPU_W-1:0]   dest_o,
    output logic [NUM_SRC-1:0]              mask_o
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        // Hold one source's fields; reset leaves it masked at priority 0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_o[s]  <= '0;
                prio_o[s] <= '0;
                dest_o[s] <= '0;
                mask_o[s] <= 1'b1;
            end else if (wr_en && wr_idx == SRC_W'(s)) begin
                vec_o[s]  <= wr_vec;
                prio_o[s] <= wr_prio;
                dest_o[s] <= wr_dest;
                mask_o[s] <= wr_mask;
            end
        end

        p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == SRC_W'(s)) |=> (prio_o[s] == $past(wr_prio) && mask_o[s] == $past(wr_mask)));
    end
endmodule

// File: rtl/prio_intc_arb.sv
// Combinational arbiter for one processor: picks the pending source with the
// highest priority strictly above the processor's level; ties go to the
// lowest index. Assumes req already excludes masked and in-service sources.
module prio_intc_arb #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3,
    parameter int PRIO_W  = 4,
    parameter int CPU_W   = 1,
    parameter int CPU_ID  = 0
) (
    input  logic [NUM_SRC-1:0]              req,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
    input  logic [NUM_SRC-1:0][CPU_W-1:0]   dest,
    input  logic [PRIO_W-1:0]               level,
    output logic                            win_valid,
    output logic [SRC_W-1:0]                win_idx,
    output logic [PRIO_W-1:0]               win_prio
);
    // Scan sources upward and keep only a strictly better priority.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = level;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (req[s] && dest[s] == CPU_W'(CPU_ID) && prio[s] > win_prio) begin
                win_valid = 1'b1;
                win_idx   = SRC_W'(s);
                win_prio  = prio[s];
            end
        end
    end
endmodule

// File: rtl/prio_intc_isr.sv
// In-service stack of one processor, kept as a bit per source ordered by the
// sources' priorities. Derives the current level and the entry to pop.
// Assumes set_en and eoi_en are never both high (one bus access per cycle).
module prio_intc_isr #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3,
    parameter int PRIO_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            set_en,
    input  logic [SRC_W-1:0]                set_idx,
    input  logic                            eoi_en,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
    output logic [NUM_SRC-1:0]              isr_q,
    output logic [PRIO_W-1:0]               level
);
    logic             top_valid;
    logic [SRC_W-1:0] top_idx;

    // Find the highest-priority in-service source, lowest index on a tie.
    always_comb begin
        top_valid = 1'b0;
        top_idx   = '0;
        level     = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (isr_q[s] && (!top_valid || prio[s] > level)) begin
                top_valid = 1'b1;
                top_idx   = SRC_W'(s);
                level     = prio[s];
            end
        end
    end

    // Push on acknowledge, pop the top entry on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else if (set_en) begin
            isr_q[set_idx] <= 1'b1;
        end else if (eoi_en && top_valid) begin
            isr_q[top_idx] <= 1'b0;
        end
    end

    p_ack_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> isr_q[$past(set_idx)]);

    p_eoi_pops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_en && !set_en && isr_q != '0) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    p_no_set_eoi_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && eoi_en));
endmodule

// File: rtl/prio_intc.sv
// Top of the nested priority interrupt controller: register decode, source
// configuration, one arbiter and one in-service stack per processor.
// Assumes one bus access per cycle; read data is combinational and the
// side effect of an acknowledge read lands on the same clock edge.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 2,
    parameter int PRIO_W  = 4,
    parameter int VEC_W   = 8,
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cascade_irq,
    input  logic [NUM_SRC-2:0] dev_irq,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_CPU-1:0] int_out
);
    localparam int SRC_W = idx_w(NUM_SRC);
    localparam int CPU_W = idx_w(NUM_CPU);
    localparam int PG_W  = ADDR_W - 12;

    logic [NUM_SRC-1:0]              irq_all;
    logic [PG_W-1:0]                 page;
    logic [11:0]                     off;
    logic                            rd_en, wr_en;
    logic                            cfg_hit, spur_hit;
    logic [SRC_W-1:0]                cfg_idx;
    logic [VEC_W-1:0]                spur_q;
    logic [NUM_SRC-1:0][VEC_W-1:0]   vec;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  prio;
    logic [NUM_SRC-1:0][CPU_W-1:0]   dest;
    logic [NUM_SRC-1:0]              mask;
    logic [NUM_SRC-1:0]              isr_any;
    logic [NUM_SRC-1:0]              pending;
    logic [NUM_CPU-1:0]              ack_hit, eoi_hit, win_valid;
    logic [NUM_CPU-1:0][SRC_W-1:0]   win_idx;
    logic [NUM_CPU-1:0][PRIO_W-1:0]  win_prio, level;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] isr_q;
    logic                            unused_wdata;

    assign irq_all      = {dev_irq, cascade_irq};
    assign page         = bus_addr[ADDR_W-1:12];
    assign off          = bus_addr[11:0];
    assign rd_en        = bus_sel && !bus_wr;
    assign wr_en        = bus_sel && bus_wr;
    assign cfg_hit      = page == PG_W'(PAGE_CFG) && off[3:0] == 4'h0 && int'(off[11:4]) < NUM_SRC;
    assign cfg_idx      = off[4 +: SRC_W];
    assign spur_hit     = page == PG_W'(PAGE_SPUR) && off == 12'h000;
    assign unused_wdata = ^bus_wdata;

    prio_intc_src_cfg #(
        .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .CPU_W(CPU_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && cfg_hit),
        .wr_idx  (cfg_idx),
        .wr_vec  (bus_wdata[FLD_VEC +: VEC_W]),
        .wr_prio (bus_wdata[FLD_PRIO +: PRIO_W]),
        .wr_dest (bus_wdata[FLD_DEST +: CPU_W]),
        .wr_mask (bus_wdata[FLD_MASK]),
        .vec_o   (vec),
        .prio_o  (prio),
        .dest_o  (dest),
        .mask_o  (mask)
    );

    // Hold the vector returned by an acknowledge that finds nothing eligible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spur_q <= '1;
        end else if (wr_en && spur_hit) begin
            spur_q <= bus_wdata[VEC_W-1:0];
        end
    end

    // A source in service on any processor is out of every arbitration.
    always_comb begin
        isr_any = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            isr_any = isr_any | isr_q[c];
        end
    end

    assign pending = irq_all & ~mask & ~isr_any;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign ack_hit[c] = rd_en && page == PG_W'(PAGE_CPU0 + c) && off == 12'(OFF_ACK);
        assign eoi_hit[c] = wr_en && page == PG_W'(PAGE_CPU0 + c) && off == 12'(OFF_EOI);

        prio_intc_arb #(
            .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .PRIO_W(PRIO_W), .CPU_W(CPU_W), .CPU_ID(c)
        ) u_arb (
            .req       (pending),
            .prio      (prio),
            .dest      (dest),
            .level     (level[c]),
            .win_valid (win_valid[c]),
            .win_idx   (win_idx[c]),
            .win_prio  (win_prio[c])
        );

        prio_intc_isr #(
            .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .PRIO_W(PRIO_W)
        ) u_isr (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (ack_hit[c] && win_valid[c]),
            .set_idx (win_idx[c]),
            .eoi_en  (eoi_hit[c]),
            .prio    (prio),
            .isr_q   (isr_q[c]),
            .level   (level[c])
        );

        p_int_above_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
            int_out[c] |-> (win_prio[c] > level[c]));

        p_int_nonzero_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
            int_out[c] |-> (prio[win_idx[c]] != '0));

        p_ack_not_twice_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_hit[c] && win_valid[c]) |-> !isr_any[win_idx[c]]);

        p_spur_keeps_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_hit[c] && !win_valid[c]) |=> (isr_q[c] == $past(isr_q[c])));

        p_masked_no_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
            win_valid[c] |-> !mask[win_idx[c]]);
    end

    assign int_out = win_valid;

    // Return the addressed register; an acknowledge gives the winner's vector.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (cfg_hit) begin
                bus_rdata[FLD_VEC +: VEC_W]   = vec[cfg_idx];
                bus_rdata[FLD_PRIO +: PRIO_W] = prio[cfg_idx];
                bus_rdata[FLD_DEST +: CPU_W]  = dest[cfg_idx];
                bus_rdata[FLD_MASK]           = mask[cfg_idx];
            end else if (spur_hit) begin
                bus_rdata[VEC_W-1:0] = spur_q;
            end else begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (ack_hit[c]) begin
                        bus_rdata[VEC_W-1:0] = win_valid[c] ? vec[win_idx[c]] : spur_q;
                    end
                end
            end
        end
    end

    p_one_ack_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit | eoi_hit));
endmodule

// File: tb/prio_intc_tb_top.sv
// Bench: a behavioural model holding the owner processor of each in-service
// source, compared with int_out on every clock and with every read.
module prio_intc_tb_top;
    localparam int NS = 8;
    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  irq;
    logic        bus_sel, bus_wr;
    logic [19:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [1:0]  int_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_prio[NS], m_vec[NS], m_dest[NS], m_owner[NS];
    bit m_mask[NS];
    int m_spur;

    always #5 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst_n(rst_n), .cascade_irq(irq[0]), .dev_irq(irq[7:1]),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_out(int_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_level(input int c);
        int lv = 0;
        for (int s = 0; s < NS; s++) if (m_owner[s] == c && m_prio[s] > lv) lv = m_prio[s];
        return lv;
    endfunction

    function automatic int m_winner(input int c);
        int best = m_level(c);
        int w = -1;
        for (int s = 0; s < NS; s++)
            if (irq[s] && !m_mask[s] && m_owner[s] < 0 && m_dest[s] == c && m_prio[s] > best) begin
                best = m_prio[s];
                w = s;
            end
        return w;
    endfunction

    function automatic int m_read(input int a);
        int pg = a >> 12;
        int of = a & 'hFFF;
        if (pg == 'h10 && (of & 'hF) == 0 && (of >> 4) < NS) begin
            int s = of >> 4;
            return (int'(m_mask[s]) << 31) | (m_dest[s] << 24) | (m_prio[s] << 16) | m_vec[s];
        end
        if (pg == 'h01 && of == 0) return m_spur;
        if (pg >= 'h20 && pg < 'h20 + NC && of == 'hA0) begin
            int w = m_winner(pg - 'h20);
            return (w >= 0) ? m_vec[w] : m_spur;
        end
        return 0;
    endfunction

    // Compare this cycle, work out the model update, apply it at the edge.
    task automatic tick(input string tag);
        int a, pg, of, push_s, push_c, pop_c, cfg_s, spur_n;
        #1;
        for (int c = 0; c < NC; c++) chk({tag, " int_out"}, int'(int_out[c]), int'(m_winner(c) >= 0));
        a = int'(bus_addr);
        pg = a >> 12;
        of = a & 'hFFF;
        push_s = -1; push_c = -1; pop_c = -1; cfg_s = -1; spur_n = -1;
        if (bus_sel && !bus_wr) begin
            chk({tag, " rdata"}, int'(bus_rdata), m_read(a));
            if (pg >= 'h20 && pg < 'h20 + NC && of == 'hA0) begin
                push_c = pg - 'h20;
                push_s = m_winner(push_c);
            end
        end
        if (bus_sel && bus_wr) begin
            if (pg >= 'h20 && pg < 'h20 + NC && of == 'hB0) pop_c = pg - 'h20;
            if (pg == 'h10 && (of & 'hF) == 0 && (of >> 4) < NS) cfg_s = of >> 4;
            if (pg == 'h01 && of == 0) spur_n = int'(bus_wdata[7:0]);
        end
        @(posedge clk);
        if (push_s >= 0) m_owner[push_s] = push_c;
        if (pop_c >= 0) begin
            int w = -1;
            int bp = -1;
            for (int s = 0; s < NS; s++) if (m_owner[s] == pop_c && m_prio[s] > bp) begin bp = m_prio[s]; w = s; end
            if (w >= 0) m_owner[w] = -1;
        end
        if (cfg_s >= 0) begin
            m_vec[cfg_s]  = int'(bus_wdata[7:0]);
            m_prio[cfg_s] = int'(bus_wdata[19:16]);
            m_dest[cfg_s] = int'(bus_wdata[24]);
            m_mask[cfg_s] = bus_wdata[31];
        end
        if (spur_n >= 0) m_spur = spur_n;
        @(negedge clk);
    endtask

    task automatic idle();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 20'(a);
        tick(tag);
        idle();
    endtask

    task automatic wr(input int a, input int d, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 20'(a); bus_wdata = 32'(d);
        tick(tag);
        idle();
    endtask

    task automatic cfg(input int s, input int v, input int p, input int d, input bit m);
        wr('h10000 + 16 * s, (int'(m) << 31) | (d << 24) | (p << 16) | v, "R2");
    endtask

    function automatic int ack_a(input int c); return 'h200A0 + (c << 12); endfunction
    function automatic int eoi_a(input int c); return 'h200B0 + (c << 12); endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NS; s++) begin m_prio[s] = 0; m_vec[s] = 0; m_dest[s] = 0; m_owner[s] = -1; m_mask[s] = 1; end
        m_spur = 'hFF;
        rst_n = 1'b0; irq = '0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, spurious acknowledge
        rd('h01000, "R1");
        rd('h10030, "R1");
        irq = 8'hFF;
        tick("R1");
        rd(ack_a(0), "R1");
        irq = '0;
        // R2: program the sources and read back
        cfg(0, 'h40, 3, 0, 0);
        cfg(1, 'h41, 5, 0, 0);
        cfg(2, 'h42, 5, 0, 0);
        cfg(3, 'h43, 9, 0, 0);
        cfg(4, 'h44, 0, 0, 0);
        cfg(5, 'h45, 7, 1, 0);
        cfg(6, 'h46, 2, 1, 0);
        cfg(7, 'h47, 12, 0, 1);
        rd('h10050, "R2");
        rd('h10070, "R2");
        // R3: priority 0 never interrupts; R11: cascade source arbitrates
        irq[4] = 1'b1; tick("R3");
        irq[0] = 1'b1; tick("R11");
        // R4: tie on priority 5 goes to source 1
        irq[1] = 1'b1; irq[2] = 1'b1; tick("R4");
        rd(ack_a(0), "R4");
        // R6: equal and lower held off; R5/R8: nothing left to acknowledge
        tick("R6");
        rd(ack_a(0), "R5");
        // R6: strictly higher priority still interrupts and nests
        irq[3] = 1'b1; tick("R6");
        rd(ack_a(0), "R6");
        irq[3] = 1'b0;
        // R7: the pop order unwinds the nesting
        wr(eoi_a(0), 0, "R7");
        tick("R7");
        irq[1] = 1'b0;
        wr(eoi_a(0), 'h1234, "R7");
        rd(ack_a(0), "R7");
        irq[2] = 1'b0;
        wr(eoi_a(0), 0, "R7");
        rd(ack_a(0), "R11");
        // R9: mask source 0 while in service; it still holds the level
        cfg(0, 'h40, 3, 0, 1);
        cfg(6, 'h46, 2, 0, 0);
        irq[6] = 1'b1; tick("R9");
        wr(eoi_a(0), 0, "R9");
        tick("R9");
        rd(ack_a(0), "R9");
        wr(eoi_a(0), 0, "R9");
        irq[6] = 1'b0; irq[0] = 1'b0;
        // R12: second processor has its own registers
        irq[5] = 1'b1; tick("R12");
        wr(eoi_a(0), 0, "R12");
        rd(ack_a(1), "R12");
        irq[3] = 1'b1; tick("R12");
        wr(eoi_a(0), 0, "R12");
        rd(ack_a(0), "R12");
        irq[3] = 1'b0;
        wr(eoi_a(1), 0, "R12");
        wr(eoi_a(0), 0, "R12");
        // R10: output falls with the request in the same cycle
        irq[3] = 1'b1; tick("R10");
        irq[3] = 1'b0; tick("R10");
        // R11: unmapped addresses read zero and change nothing
        irq[3] = 1'b1;
        rd('h220A0, "R11");
        rd('h200A4, "R11");
        rd('h10080, "R11");
        tick("R11");
        irq[3] = 1'b0;
        // R8: programmed spurious vector
        wr('h01000, 'h3C, "R8");
        rd(ack_a(1), "R8");
        // Random phase across all requirements (R4, R6, R7)
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 15));
            irq = 8'($urandom);
            if (r < 5) rd(ack_a(r & 1), "R4");
            else if (r < 9) wr(eoi_a(r & 1), 0, "R7");
            else if (r == 9) cfg(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
                                 int'($urandom_range(0, 15)), int'($urandom_range(0, 1)),
                                 1'($urandom_range(0, 3) == 0));
            else tick("R6");
        end
        finish_run();
    end
endmodule